// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segment register plus a 16-bit offset into a physical address. It holds four 16-bit segment registers (code, data, stack, extra) and works in one of two modes. In real mode the address is the segment value times sixteen plus the offset. A wraparound control can clear bit 20 of that sum, which makes addresses above one megabyte wrap around to the bottom of memory.

In protected mode the chosen segment register holds a selector. The selector picks a descriptor from one of two small on-chip tables, a global table and a local table. The descriptor supplies a 32-bit base and a 20-bit byte limit. The block checks the offset against the limit and adds it to the base. The selector's privilege field is passed through with the result.

Software or a sequencer loads the segment registers, the descriptor tables and the mode controls through three write ports. It then issues translate requests one per cycle. Each request is answered by a one-cycle response pulse in the following cycle.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset the unit is in real mode with the wraparound mask clear. The code segment holds 0xF000, the other segments hold 0, every descriptor has base 0 and limit 0, and rsp_valid_o is low.
- R2: In real mode the response address is ({segment,4'h0} + offset) as a 21-bit sum, zero-extended to 32 bits. rsp_rpl_o is 0 and both fault flags are low.
- R3: With the wraparound mask set, bit 20 of the real-mode sum is forced to 0 (0xFFFF:0x0020 gives 0x00010). With the mask clear the carry is kept (0xFFFF:0x0020 gives 0x100010).
- R4: A request names its segment register with a 2-bit code: 0 code, 1 data, 2 stack, 3 extra. The same codes address the segment write port.
- R5: In protected mode the selector is decoded as index = bits 15:3, table select = bit 2 (0 global, 1 local) and privilege = bits 1:0. The privilege field appears unchanged on rsp_rpl_o.
- R6: In protected mode a request without a fault returns (descriptor base + zero-extended offset) modulo 2^32.
- R7: A protected-mode selector index of 8 or more sets rsp_idx_fault_o and returns address 0.
- R8: A protected-mode offset greater than the descriptor limit sets rsp_lim_fault_o and returns address 0. An offset equal to the limit is accepted.
- R9: Each request sampled on a clock edge produces rsp_valid_o high for exactly the following cycle, including requests in back-to-back cycles. When no response is due, all response outputs are 0.
- R10: Writes to the segment registers, the descriptor tables and the mode controls take effect for requests sampled on later edges. A request sampled on the same edge as a write uses the old value.
- R11: An index fault takes priority: when it is raised, the limit fault is low whatever the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write mode controls |
| cfg_prot_i | input | 1 | Mode to write: 1 protected, 0 real |
| cfg_a20m_i | input | 1 | Wraparound mask to write |
| sreg_we_i | input | 1 | Write a segment register |
| sreg_sel_i | input | 2 | Segment register code for the write |
| sreg_wdata_i | input | 16 | Segment value to write |
| dt_we_i | input | 1 | Write a descriptor |
| dt_tbl_i | input | 1 | Table for the write: 0 global, 1 local |
| dt_idx_i | input | 3 | Descriptor entry for the write |
| dt_base_i | input | 32 | Descriptor base to write |
| dt_limit_i | input | 20 | Descriptor byte limit to write |
| req_valid_i | input | 1 | Translate request |
| req_sreg_i | input | 2 | Segment register code for the request |
| req_off_i | input | 16 | Offset for the request |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_addr_o | output | 32 | Physical address, 0 on a fault |
| rsp_rpl_o | output | 2 | Privilege field passed through (0 in real mode) |
| rsp_idx_fault_o | output | 1 | Selector index out of table range |
| rsp_lim_fault_o | output | 1 | Offset beyond descriptor limit |

## Verification
The hardest case to reach from the ports is a write and a request to the same segment register on the same edge, where the response must still use the old value. The stimulus drives both in one cycle and then repeats the request alone. The carry-out cases are also hard to hit by chance: a real-mode sum that crosses one megabyte with and without the mask, and a protected-mode base near the top of the space whose sum wraps. Offsets just at and just past a limit are driven on purpose. Every request pushes its expected response into a scoreboard queue, and a monitor pops and compares each pulse. The expected values come from a model of the segments, tables and mode that the bench keeps itself.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int SEG_W   = 16;
    localparam int OFF_W   = 16;
    localparam int PA_W    = 32;
    localparam int LIM_W   = 20;
    localparam int DT_DEP  = 8;
    localparam int DT_IW   = $clog2(DT_DEP);

    typedef enum logic [1:0] {
        SR_CODE  = 2'd0,
        SR_DATA  = 2'd1,
        SR_STACK = 2'd2,
        SR_EXTRA = 2'd3
    } sreg_e;

    typedef struct packed {
        logic [PA_W-1:0]  base;
        logic [LIM_W-1:0] limit;
    } desc_t;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] addr;
        logic [1:0]      rpl;
        logic            idx_fault;
        logic            lim_fault;
    } rsp_t;

endpackage

// File: rtl/sx_seg_file.sv
module sx_seg_file #(
    parameter int          SEG_W    = 16,
    parameter int          NSEG     = 4,
    parameter logic [15:0] RESET_CS = 16'hF000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [$clog2(NSEG)-1:0]  wsel_i,
    input  logic [SEG_W-1:0]         wdata_i,
    input  logic [$clog2(NSEG)-1:0]  rsel_i,
    output logic [SEG_W-1:0]         rdata_o
);
    logic [NSEG-1:0][SEG_W-1:0] seg_d, seg_q;

    always_comb begin
        seg_d = seg_q;
        if (we_i) begin
            seg_d[wsel_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q    <= '0;
            seg_q[0] <= SEG_W'(RESET_CS);
        end else begin
            seg_q <= seg_d;
        end
    end

    assign rdata_o = seg_q[rsel_i];

    // R10: a write lands in the addressed register on the next edge
    assert_seg_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> seg_q[$past(wsel_i)] == $past(wdata_i));

endmodule

// File: rtl/sx_desc_table.sv
module sx_desc_table
    import seg_xlate_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] widx_i,
    input  desc_t         wdesc_i,
    input  logic [IW-1:0] ridx_i,
    output desc_t         rdesc_o
);
    desc_t ent_d [DEPTH];
    desc_t ent_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (we_i) begin
            ent_d[widx_i] = wdesc_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    assign rdesc_o = ent_q[ridx_i];

    // R10: a loaded descriptor is held from the next edge
    assert_desc_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ent_q[$past(widx_i)] == $past(wdesc_i));

endmodule

// File: rtl/sx_addr_calc.sv
module sx_addr_calc
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int PA_W  = 32,
    parameter int LIM_W = 20,
    parameter int DEPTH = 8
) (
    input  logic             prot_i,
    input  logic             a20m_i,
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    input  desc_t            desc_i,
    output logic [PA_W-1:0]  addr_o,
    output logic [1:0]       rpl_o,
    output logic             idx_fault_o,
    output logic             lim_fault_o
);
    localparam int REAL_W = SEG_W + 4 + 1;
    localparam int WRAP_B = SEG_W + 4;
    localparam int SIX_W  = SEG_W - 3;

    localparam logic [SIX_W-1:0] DEPTH_V = SIX_W'(DEPTH);

    logic [REAL_W-1:0] real_sum;
    logic [SIX_W-1:0]  sel_idx;
    logic [LIM_W-1:0]  off_lim;
    logic [PA_W-1:0]   prot_sum;

    always_comb begin
        real_sum = REAL_W'({seg_i, 4'h0}) + REAL_W'(off_i);
        if (a20m_i) begin
            real_sum[WRAP_B] = 1'b0;
        end
        sel_idx  = seg_i[SEG_W-1:3];
        off_lim  = LIM_W'(off_i);
        prot_sum = desc_i.base + PA_W'(off_i);

        addr_o      = '0;
        rpl_o       = 2'b00;
        idx_fault_o = 1'b0;
        lim_fault_o = 1'b0;
        if (!prot_i) begin
            addr_o = PA_W'(real_sum);
        end else begin
            rpl_o = seg_i[1:0];
            if (sel_idx >= DEPTH_V) begin
                idx_fault_o = 1'b1;
            end else if (off_lim > desc_i.limit) begin
                lim_fault_o = 1'b1;
            end else begin
                addr_o = prot_sum;
            end
        end
    end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int          SEG_W    = seg_xlate_pkg::SEG_W,
    parameter int          OFF_W    = seg_xlate_pkg::OFF_W,
    parameter int          PA_W     = seg_xlate_pkg::PA_W,
    parameter int          LIM_W    = seg_xlate_pkg::LIM_W,
    parameter int          DT_DEP   = seg_xlate_pkg::DT_DEP,
    parameter logic [15:0] RESET_CS = 16'hF000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic              cfg_prot_i,
    input  logic              cfg_a20m_i,
    input  logic              sreg_we_i,
    input  logic [1:0]        sreg_sel_i,
    input  logic [SEG_W-1:0]  sreg_wdata_i,
    input  logic              dt_we_i,
    input  logic              dt_tbl_i,
    input  logic [2:0]        dt_idx_i,
    input  logic [PA_W-1:0]   dt_base_i,
    input  logic [LIM_W-1:0]  dt_limit_i,
    input  logic              req_valid_i,
    input  logic [1:0]        req_sreg_i,
    input  logic [OFF_W-1:0]  req_off_i,
    output logic              rsp_valid_o,
    output logic [PA_W-1:0]   rsp_addr_o,
    output logic [1:0]        rsp_rpl_o,
    output logic              rsp_idx_fault_o,
    output logic              rsp_lim_fault_o
);
    localparam int IW     = $clog2(DT_DEP);
    localparam int NTBL   = 2;
    localparam int SIX_W  = SEG_W - 3;
    localparam logic [SIX_W-1:0] DEPTH_V = SIX_W'(DT_DEP);

    typedef struct packed {
        logic prot;
        logic a20m;
        rsp_t rsp;
    } state_t;

    state_t st_d, st_q;

    logic [SEG_W-1:0] seg_rd;
    desc_t            tbl_rd [NTBL];
    desc_t            desc_sel;
    desc_t            wdesc;
    logic [IW-1:0]    ridx;
    logic [PA_W-1:0]  c_addr;
    logic [1:0]       c_rpl;
    logic             c_idxf, c_limf;

    sx_seg_file #(
        .SEG_W    (SEG_W),
        .NSEG     (4),
        .RESET_CS (RESET_CS)
    ) u_segs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (sreg_we_i),
        .wsel_i  (sreg_sel_i),
        .wdata_i (sreg_wdata_i),
        .rsel_i  (req_sreg_i),
        .rdata_o (seg_rd)
    );

    assign wdesc = '{base: dt_base_i, limit: dt_limit_i};
    assign ridx  = seg_rd[3 +: IW];

    for (genvar t = 0; t < NTBL; t++) begin : g_tbl
        logic tbl_we;
        assign tbl_we = dt_we_i && (dt_tbl_i == t[0]);
        sx_desc_table #(
            .DEPTH (DT_DEP),
            .IW    (IW)
        ) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (tbl_we),
            .widx_i  (dt_idx_i[IW-1:0]),
            .wdesc_i (wdesc),
            .ridx_i  (ridx),
            .rdesc_o (tbl_rd[t])
        );
    end

    assign desc_sel = tbl_rd[seg_rd[2]];

    sx_addr_calc #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .PA_W  (PA_W),
        .LIM_W (LIM_W),
        .DEPTH (DT_DEP)
    ) u_calc (
        .prot_i      (st_q.prot),
        .a20m_i      (st_q.a20m),
        .seg_i       (seg_rd),
        .off_i       (req_off_i),
        .desc_i      (desc_sel),
        .addr_o      (c_addr),
        .rpl_o       (c_rpl),
        .idx_fault_o (c_idxf),
        .lim_fault_o (c_limf)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rsp = '0;
        if (cfg_we_i) begin
            st_d.prot = cfg_prot_i;
            st_d.a20m = cfg_a20m_i;
        end
        if (req_valid_i) begin
            st_d.rsp.valid     = 1'b1;
            st_d.rsp.addr      = c_addr;
            st_d.rsp.rpl       = c_rpl;
            st_d.rsp.idx_fault = c_idxf;
            st_d.rsp.lim_fault = c_limf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o     = st_q.rsp.valid;
    assign rsp_addr_o      = st_q.rsp.addr;
    assign rsp_rpl_o       = st_q.rsp.rpl;
    assign rsp_idx_fault_o = st_q.rsp.idx_fault;
    assign rsp_lim_fault_o = st_q.rsp.lim_fault;

    assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);

    assert_rsp_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_o |-> (rsp_addr_o == '0 && rsp_rpl_o == 2'b00
                          && !rsp_idx_fault_o && !rsp_lim_fault_o));

    assert_real_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !st_q.prot) |=> (!rsp_idx_fault_o && !rsp_lim_fault_o
            && rsp_rpl_o == 2'b00 && rsp_addr_o[PA_W-1:SEG_W+5] == '0));

    assert_a20_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !st_q.prot && st_q.a20m) |=> !rsp_addr_o[SEG_W+4]);

    assert_rpl_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && st_q.prot) |=> rsp_rpl_o == $past(seg_rd[1:0]));

    assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && st_q.prot && seg_rd[SEG_W-1:3] >= DEPTH_V) |=> rsp_idx_fault_o);

    assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_idx_fault_o || rsp_lim_fault_o) |-> rsp_addr_o == '0);

    assert_fault_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_idx_fault_o && rsp_lim_fault_o));

endmodule

// File: tb/tb_seg_xlate_top.sv
module tb_seg_xlate_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  rpl;
        logic        idxf;
        logic        limf;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, cfg_prot = 0, cfg_a20m = 0;
    logic        sreg_we = 0;
    logic [1:0]  sreg_sel = 0;
    logic [15:0] sreg_wdata = 0;
    logic        dt_we = 0, dt_tbl = 0;
    logic [2:0]  dt_idx = 0;
    logic [31:0] dt_base = 0;
    logic [19:0] dt_limit = 0;
    logic        req_valid = 0;
    logic [1:0]  req_sreg = 0;
    logic [15:0] req_off = 0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic [1:0]  rsp_rpl;
    logic        rsp_idxf, rsp_limf;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    exp_t  exp_q[$];
    string tag_q[$];

    logic [15:0] m_seg [4];
    logic [31:0] m_base [2][8];
    logic [19:0] m_lim  [2][8];
    logic        m_prot, m_a20;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate_top dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we), .cfg_prot_i(cfg_prot), .cfg_a20m_i(cfg_a20m),
        .sreg_we_i(sreg_we), .sreg_sel_i(sreg_sel), .sreg_wdata_i(sreg_wdata),
        .dt_we_i(dt_we), .dt_tbl_i(dt_tbl), .dt_idx_i(dt_idx),
        .dt_base_i(dt_base), .dt_limit_i(dt_limit),
        .req_valid_i(req_valid), .req_sreg_i(req_sreg), .req_off_i(req_off),
        .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr), .rsp_rpl_o(rsp_rpl),
        .rsp_idx_fault_o(rsp_idxf), .rsp_lim_fault_o(rsp_limf)
    );

    function automatic exp_t model(logic [1:0] s, logic [15:0] off);
        exp_t e;
        logic [20:0] sum;
        logic [12:0] idx;
        logic [15:0] seg;
        e = '0;
        seg = m_seg[s];
        if (!m_prot) begin
            sum = {1'b0, seg, 4'h0} + {5'h0, off};
            if (m_a20) sum[20] = 1'b0;
            e.addr = {11'h0, sum};
        end else begin
            e.rpl = seg[1:0];
            idx = seg[15:3];
            if (idx >= 13'd8) e.idxf = 1'b1;
            else if ({4'h0, off} > m_lim[seg[2]][idx[2:0]]) e.limf = 1'b1;
            else e.addr = m_base[seg[2]][idx[2:0]] + {16'h0, off};
        end
        return e;
    endfunction

    task automatic idle();
        @(negedge clk);
        cfg_we = 0; sreg_we = 0; dt_we = 0; req_valid = 0;
    endtask

    task automatic req(logic [1:0] s, logic [15:0] off, string tag);
        @(negedge clk);
        cfg_we = 0; sreg_we = 0; dt_we = 0;
        req_valid = 1; req_sreg = s; req_off = off;
        exp_q.push_back(model(s, off));
        tag_q.push_back(tag);
    endtask

    task automatic wr_seg(logic [1:0] s, logic [15:0] v);
        @(negedge clk);
        req_valid = 0; cfg_we = 0; dt_we = 0;
        sreg_we = 1; sreg_sel = s; sreg_wdata = v;
        m_seg[s] = v;
        idle();
    endtask

    task automatic wr_cfg(logic p, logic a);
        @(negedge clk);
        req_valid = 0; sreg_we = 0; dt_we = 0;
        cfg_we = 1; cfg_prot = p; cfg_a20m = a;
        m_prot = p; m_a20 = a;
        idle();
    endtask

    task automatic wr_desc(logic t, logic [2:0] i, logic [31:0] b, logic [19:0] l);
        @(negedge clk);
        req_valid = 0; sreg_we = 0; cfg_we = 0;
        dt_we = 1; dt_tbl = t; dt_idx = i; dt_base = b; dt_limit = l;
        m_base[t][i] = b; m_lim[t][i] = l;
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected response addr=%h expected none", rsp_addr);
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({rsp_addr, rsp_rpl, rsp_idxf, rsp_limf} !== e) begin
                    errors++;
                    $display("FAIL %s actual addr=%h rpl=%0d idxf=%b limf=%b expected addr=%h rpl=%0d idxf=%b limf=%b",
                             t, rsp_addr, rsp_rpl, rsp_idxf, rsp_limf, e.addr, e.rpl, e.idxf, e.limf);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        m_seg[0] = 16'hF000; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0;
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 8; i++) begin
                m_base[t][i] = 0; m_lim[t][i] = 0;
            end
        m_prot = 0; m_a20 = 0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 rsp_valid actual=%b expected=0", rsp_valid);
        end

        // R1 reset segments, R2 real mode
        req(0, 16'h0000, "R1 code reset");
        req(1, 16'h1234, "R1 data reset");
        idle();
        // R4 segment codes, R2 real-mode sums
        wr_seg(1, 16'h2000);
        wr_seg(2, 16'h1234);
        wr_seg(3, 16'hABCD);
        req(1, 16'h0100, "R2 R4 data");
        req(2, 16'hFFFF, "R2 R4 stack");
        req(3, 16'h0010, "R2 R4 extra");
        idle();
        // R3 wraparound
        wr_seg(3, 16'hFFFF);
        req(3, 16'h0020, "R3 carry kept");
        req(3, 16'hFFFF, "R3 carry kept max");
        idle();
        wr_cfg(0, 1);
        req(3, 16'h0020, "R3 masked");
        req(3, 16'hFFFF, "R3 masked max");
        idle();
        // R10 same-edge write and request
        @(negedge clk);
        sreg_we = 1; sreg_sel = 1; sreg_wdata = 16'h3000;
        req_valid = 1; req_sreg = 1; req_off = 16'h0004;
        exp_q.push_back(model(1, 16'h0004));
        tag_q.push_back("R10 old value");
        m_seg[1] = 16'h3000;
        req(1, 16'h0004, "R10 new value");
        idle();

        // protected mode
        wr_desc(0, 1, 32'h0010_0000, 20'h00FFF);
        wr_desc(0, 7, 32'hFFFF_FFF0, 20'hFFFFF);
        wr_desc(1, 1, 32'h4000_0000, 20'h0000F);
        wr_cfg(1, 0);
        wr_seg(1, 16'h000B);
        req(1, 16'h0010, "R5 R6 global");
        req(1, 16'h0FFF, "R8 at limit");
        req(1, 16'h1000, "R8 past limit");
        idle();
        wr_seg(1, 16'h000E);
        req(1, 16'h000F, "R5 local");
        req(1, 16'h0010, "R8 local past");
        idle();
        wr_seg(2, 16'h0038);
        req(2, 16'h0020, "R6 wrap");
        idle();
        wr_seg(3, 16'h0041);
        req(3, 16'h0000, "R7 R11 index 8");
        req(3, 16'hFFFF, "R11 index fault over limit");
        req(0, 16'h0000, "R7 code selector");
        idle();
        wr_seg(3, 16'hFFFF);
        req(3, 16'h0001, "R7 max index");
        idle();
        wr_seg(2, 16'h0004);
        req(2, 16'h0000, "R1 descriptor zero");
        req(2, 16'h0001, "R1 R8 zero limit");
        idle();
        // R10 mode change, back to real
        wr_cfg(0, 0);
        req(1, 16'h0003, "R10 R2 back to real");
        req(2, 16'h0010, "R9 back-to-back");
        idle();
        idle();
        idle();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9 missing responses actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule